// File: doc/BRIEF.md
# Clock Synthesizer Divider Search Engine

This engine picks the divider settings for a display clock synthesizer. A caller gives it a target dot frequency and the reference frequency, then pulses `start`. The engine walks every legal combination of the input divider `n`, the two feedback dividers `m1` and `m2`, and the post divider `p1`, with one candidate per clock. The second post divider `p2` stays fixed. For each candidate it works out the feedback product, the post product, the oscillator frequency and the dot frequency with integer multiply and divide. It then checks all of them against their limits.

A candidate whose dot frequency equals the target ends the search at once. If there is no exact hit, the engine keeps the valid candidate that lies closest above the target. When the walk ends it reports that candidate, or raises `not_found` when no valid candidate lay above the target. The result stays on the outputs until the next search starts. Programming the analog loop itself is left to the caller.

Top module: `pll_div_search`

## Requirements
- R1: After reset, `done`, `valid` and `not_found` are low and `n_o`, `m1_o`, `m2_o` and `p1_o` are zero.
- R2: Candidates are visited one per clock in a fixed order. `n` is the outermost loop and rises from 3 to 8. Inside it, `m1` falls from 20 to 10. Inside that, `m2` falls from 9 to 5. `p1` is the innermost loop and falls from 8 to 1, for 2640 candidates in all. If the search exits on the candidate with zero-based index k, `done` rises on the (k+1)-th rising edge after the one that sampled `start`. A search with no exact hit raises `done` on the 2640th edge.
- R3: The derived values use integer arithmetic with truncating division:
  - m = 5·(m1+2) + (m2+2)
  - p = p1·p2
  - oscillator = ref·m / (n+2)
  - dot = oscillator / p
- R4: A candidate is valid only if all of these hold, with every bound inclusive:
  - m1 > m2
  - 70 ≤ m ≤ 120
  - 5 ≤ p ≤ 80
  - 20 MHz ≤ dot ≤ 400 MHz
  - 1.4 GHz ≤ oscillator ≤ 2.8 GHz
- R5: The first valid candidate whose dot frequency equals the target ends the search. The engine reports that candidate with `valid` high and `not_found` low.
- R6: When there is no exact hit, the engine reports the valid candidate with dot > target and the smallest dot − target, provided that difference is below 0xFFFFFFFF. On a tie, the earliest candidate in visiting order wins.
- R7: When no valid candidate lies above the target and none matches exactly, `done` comes with `not_found` high, `valid` low and all four divider outputs zero.
- R8: `done` is high for exactly one cycle. The flags and the divider outputs hold until the next accepted `start`, which clears `valid` and `not_found`.
- R9: A `start` pulse during a search is ignored. The running search finishes with its original target, in its original cycle count.
- R10: `p2_o` always reads 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a search when idle |
| target_hz | input | 64 | Requested dot frequency in Hz |
| ref_hz | input | 64 | Reference frequency in Hz |
| n_o | output | 5 | Chosen input divider |
| m1_o | output | 5 | Chosen first feedback divider |
| m2_o | output | 5 | Chosen second feedback divider |
| p1_o | output | 5 | Chosen post divider |
| p2_o | output | 5 | Fixed second post divider (10) |
| valid | output | 1 | Result holds a usable setting |
| done | output | 1 | One-cycle end-of-search pulse |
| not_found | output | 1 | No candidate met the rules |

## Verification
Several directed targets each isolate one rule:
- A frequency that one candidate hits exactly shows the early exit and its cycle count.
- A frequency one hertz below such a hit shows the strictly-above rule.
- A frequency above every reachable dot shows the `not_found` path.
- A one-hertz target exercises the smallest-dot winner.

Seeded random targets around the legal dot range, at a 96 MHz reference and a 100 MHz reference, compare the chosen dividers and the exit cycle with a loop model. That comparison separates a wrong visiting order or tie rule from a wrong validity bound. One search receives a second `start` with a different target partway through, which tells apart an engine that ignores it from one that restarts.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int unsigned DIV_W = 5;

  typedef struct packed {
    logic [DIV_W-1:0] n;
    logic [DIV_W-1:0] m1;
    logic [DIV_W-1:0] m2;
    logic [DIV_W-1:0] p1;
  } cand_t;

  typedef enum logic {S_IDLE, S_RUN} srch_state_t;
endpackage

// File: rtl/pll_digit.sv
module pll_digit #(
  parameter int unsigned W    = 5,
  parameter int unsigned LO   = 0,
  parameter int unsigned HI   = 1,
  parameter bit          DESC = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] val,
  output logic         at_end
);
  localparam logic [W-1:0] FIRST = DESC ? W'(HI) : W'(LO);
  localparam logic [W-1:0] LAST  = DESC ? W'(LO) : W'(HI);

  logic [W-1:0] val_d;

  assign at_end = (val == LAST);

  always_comb begin
    val_d = val;
    if (load)
      val_d = FIRST;
    else if (step)
      val_d = at_end ? FIRST : (DESC ? val - W'(1) : val + W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      val <= FIRST;
    else if (load || step)
      val <= val_d;
  end

  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (val >= W'(LO)) && (val <= W'(HI)));
endmodule

// File: rtl/pll_cand_iter.sv
module pll_cand_iter
  import pll_search_pkg::*;
#(
  parameter int unsigned N_LO  = 3,
  parameter int unsigned N_HI  = 8,
  parameter int unsigned M1_LO = 10,
  parameter int unsigned M1_HI = 20,
  parameter int unsigned M2_LO = 5,
  parameter int unsigned M2_HI = 9,
  parameter int unsigned P1_LO = 1,
  parameter int unsigned P1_HI = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  output cand_t cand,
  output logic  last
);
  logic end_n, end_m1, end_m2, end_p1;
  logic stp_m2, stp_m1, stp_n;

  assign stp_m2 = step & end_p1;
  assign stp_m1 = stp_m2 & end_m2;
  assign stp_n  = stp_m1 & end_m1;
  assign last   = end_n & end_m1 & end_m2 & end_p1;

  pll_digit #(.W(DIV_W), .LO(N_LO), .HI(N_HI), .DESC(1'b0)) u_n (
    .clk(clk), .rst_n(rst_n), .load(load), .step(stp_n),
    .val(cand.n), .at_end(end_n));
  pll_digit #(.W(DIV_W), .LO(M1_LO), .HI(M1_HI), .DESC(1'b1)) u_m1 (
    .clk(clk), .rst_n(rst_n), .load(load), .step(stp_m1),
    .val(cand.m1), .at_end(end_m1));
  pll_digit #(.W(DIV_W), .LO(M2_LO), .HI(M2_HI), .DESC(1'b1)) u_m2 (
    .clk(clk), .rst_n(rst_n), .load(load), .step(stp_m2),
    .val(cand.m2), .at_end(end_m2));
  pll_digit #(.W(DIV_W), .LO(P1_LO), .HI(P1_HI), .DESC(1'b1)) u_p1 (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .val(cand.p1), .at_end(end_p1));
endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval
  import pll_search_pkg::*;
#(
  parameter int unsigned FREQ_W = 64,
  parameter int unsigned P2_FIX = 10,
  parameter int unsigned M_LO   = 70,
  parameter int unsigned M_HI   = 120,
  parameter int unsigned P_LO   = 5,
  parameter int unsigned P_HI   = 80,
  parameter logic [FREQ_W-1:0] DOT_LO = 64'd20_000_000,
  parameter logic [FREQ_W-1:0] DOT_HI = 64'd400_000_000,
  parameter logic [FREQ_W-1:0] VCO_LO = 64'd1_400_000_000,
  parameter logic [FREQ_W-1:0] VCO_HI = 64'd2_800_000_000
) (
  input  logic [FREQ_W-1:0] ref_hz,
  input  cand_t             cand,
  output logic [FREQ_W-1:0] dot,
  output logic              ok
);
  localparam logic [FREQ_W-1:0] K2   = FREQ_W'(2);
  localparam logic [FREQ_W-1:0] K5   = FREQ_W'(5);
  localparam logic [FREQ_W-1:0] P2_W = FREQ_W'(P2_FIX);
  localparam logic [FREQ_W-1:0] MLW  = FREQ_W'(M_LO);
  localparam logic [FREQ_W-1:0] MHW  = FREQ_W'(M_HI);
  localparam logic [FREQ_W-1:0] PLW  = FREQ_W'(P_LO);
  localparam logic [FREQ_W-1:0] PHW  = FREQ_W'(P_HI);

  logic [FREQ_W-1:0] m_v, p_v, vco;

  always_comb begin
    m_v = K5 * (FREQ_W'(cand.m1) + K2) + (FREQ_W'(cand.m2) + K2);
    p_v = FREQ_W'(cand.p1) * P2_W;
    vco = (ref_hz * m_v) / (FREQ_W'(cand.n) + K2);
    dot = (p_v != '0) ? vco / p_v : '0;
    ok  = (cand.m1 > cand.m2) &&
          (m_v >= MLW) && (m_v <= MHW) &&
          (p_v >= PLW) && (p_v <= PHW) &&
          (dot >= DOT_LO) && (dot <= DOT_HI) &&
          (vco >= VCO_LO) && (vco <= VCO_HI);
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int unsigned FREQ_W = 64,
  parameter int unsigned N_LO   = 3,
  parameter int unsigned N_HI   = 8,
  parameter int unsigned M1_LO  = 10,
  parameter int unsigned M1_HI  = 20,
  parameter int unsigned M2_LO  = 5,
  parameter int unsigned M2_HI  = 9,
  parameter int unsigned P1_LO  = 1,
  parameter int unsigned P1_HI  = 8,
  parameter int unsigned P2_FIX = 10,
  parameter logic [FREQ_W-1:0] BEST_INIT = 64'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] target_hz,
  input  logic [FREQ_W-1:0] ref_hz,
  output logic [DIV_W-1:0]  n_o,
  output logic [DIV_W-1:0]  m1_o,
  output logic [DIV_W-1:0]  m2_o,
  output logic [DIV_W-1:0]  p1_o,
  output logic [DIV_W-1:0]  p2_o,
  output logic              valid,
  output logic              done,
  output logic              not_found
);
  srch_state_t       state_q, state_d;
  logic [FREQ_W-1:0] tgt_q, tgt_d, ref_q, ref_d;
  logic [FREQ_W-1:0] bdiff_q, bdiff_d;
  cand_t             best_q, best_d, res_q, res_d;
  logic              hit_q, hit_d;
  logic              valid_q, valid_d, nf_q, nf_d, done_q, done_d;

  cand_t             cand;
  logic              last, it_load, it_step;
  logic [FREQ_W-1:0] dot, diff;
  logic              cand_ok, upd;

  pll_cand_iter #(
    .N_LO(N_LO), .N_HI(N_HI), .M1_LO(M1_LO), .M1_HI(M1_HI),
    .M2_LO(M2_LO), .M2_HI(M2_HI), .P1_LO(P1_LO), .P1_HI(P1_HI)
  ) u_iter (
    .clk(clk), .rst_n(rst_n), .load(it_load), .step(it_step),
    .cand(cand), .last(last));

  pll_cand_eval #(.FREQ_W(FREQ_W), .P2_FIX(P2_FIX)) u_eval (
    .ref_hz(ref_q), .cand(cand), .dot(dot), .ok(cand_ok));

  assign diff = dot - tgt_q;
  assign upd  = cand_ok && (dot > tgt_q) && (diff < bdiff_q);

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    ref_d   = ref_q;
    bdiff_d = bdiff_q;
    best_d  = best_q;
    hit_d   = hit_q;
    res_d   = res_q;
    valid_d = valid_q;
    nf_d    = nf_q;
    done_d  = 1'b0;
    it_load = 1'b0;
    it_step = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          tgt_d   = target_hz;
          ref_d   = ref_hz;
          bdiff_d = BEST_INIT;
          best_d  = '0;
          hit_d   = 1'b0;
          valid_d = 1'b0;
          nf_d    = 1'b0;
          it_load = 1'b1;
          state_d = S_RUN;
        end
      end
      default: begin
        it_step = 1'b1;
        if (cand_ok && (dot == tgt_q)) begin
          res_d   = cand;
          valid_d = 1'b1;
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          if (upd) begin
            best_d  = cand;
            bdiff_d = diff;
            hit_d   = 1'b1;
          end
          if (last) begin
            res_d   = upd ? cand : best_q;
            valid_d = upd | hit_q;
            nf_d    = ~(upd | hit_q);
            done_d  = 1'b1;
            state_d = S_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tgt_q   <= '0;
      ref_q   <= '0;
      bdiff_q <= '0;
      best_q  <= '0;
      hit_q   <= 1'b0;
      res_q   <= '0;
      valid_q <= 1'b0;
      nf_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      ref_q   <= ref_d;
      bdiff_q <= bdiff_d;
      best_q  <= best_d;
      hit_q   <= hit_d;
      res_q   <= res_d;
      valid_q <= valid_d;
      nf_q    <= nf_d;
      done_q  <= done_d;
    end
  end

  assign n_o       = res_q.n;
  assign m1_o      = res_q.m1;
  assign m2_o      = res_q.m2;
  assign p1_o      = res_q.p1;
  assign p2_o      = DIV_W'(P2_FIX);
  assign valid     = valid_q;
  assign not_found = nf_q;
  assign done      = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && nf_q));
  // R5
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (valid_q ^ nf_q));
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RUN && start) |=> $stable(tgt_q));
  // R6
  best_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> (bdiff_q < BEST_INIT));
endmodule

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] target_hz = '0;
  logic [63:0] ref_hz = '0;
  logic [4:0]  n_o, m1_o, m2_o, p1_o, p2_o;
  logic        valid, done, not_found;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pll_div_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
    .ref_hz(ref_hz), .n_o(n_o), .m1_o(m1_o), .m2_o(m2_o), .p1_o(p1_o),
    .p2_o(p2_o), .valid(valid), .done(done), .not_found(not_found));

  task automatic check(input string req, input longint unsigned act,
                       input longint unsigned exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Loop model written from the requirements (R2 order, R3 math, R4 limits)
  task automatic model(input longint unsigned t, input longint unsigned r,
                       output bit ok, output int en, output int em1,
                       output int em2, output int ep1, output int steps);
    longint unsigned bd = 64'hFFFF_FFFF;
    int idx = 0;
    ok = 0; en = 0; em1 = 0; em2 = 0; ep1 = 0; steps = 2640;
    for (int n = 3; n <= 8; n++)
      for (int m1 = 20; m1 >= 10; m1--)
        for (int m2 = 9; m2 >= 5; m2--)
          for (int p1 = 8; p1 >= 1; p1--) begin
            longint unsigned m = 5 * (m1 + 2) + (m2 + 2);
            longint unsigned p = p1 * 10;
            longint unsigned vco = (r * m) / (n + 2);
            longint unsigned dot = vco / p;
            bit good = (m1 > m2) && m >= 70 && m <= 120 && p >= 5 && p <= 80 &&
                       dot >= 64'd20_000_000 && dot <= 64'd400_000_000 &&
                       vco >= 64'd1_400_000_000 && vco <= 64'd2_800_000_000;
            if (good && dot == t) begin
              ok = 1; en = n; em1 = m1; em2 = m2; ep1 = p1;
              steps = idx + 1;
              return;
            end
            if (good && dot > t && (dot - t) < bd) begin
              bd = dot - t; ok = 1; en = n; em1 = m1; em2 = m2; ep1 = p1;
            end
            idx++;
          end
  endtask

  task automatic run(input string tag, input longint unsigned t,
                     input longint unsigned r, input int inject);
    bit ok; int en, em1, em2, ep1, steps;
    int cyc = 0;
    model(t, r, ok, en, em1, em2, ep1, steps);
    @(negedge clk);
    start = 1'b1; target_hz = t; ref_hz = r;
    @(posedge clk);
    forever begin
      @(negedge clk);
      start = (cyc == inject);
      target_hz = (cyc == inject) ? t + 64'd7 : t;
      @(posedge clk); #1;
      cyc++;
      if (done || cyc > 3000) break;
    end
    start = 1'b0;
    $display("[TB] %s target=%0d", tag, t);
    check("R2 exit cycle", cyc, steps);
    check("R5/R7 valid", valid, ok);
    check("R7 not_found", not_found, !ok);
    check("R6/R3/R4 n", n_o, en);
    check("R6/R3/R4 m1", m1_o, em1);
    check("R6/R3/R4 m2", m2_o, em2);
    check("R6/R3/R4 p1", p1_o, ep1);
    check("R10 p2", p2_o, 10);
    @(posedge clk); #1;
    check("R8 done pulse", done, 0);
    check("R8 hold valid", valid, ok);
    check("R8 hold n", n_o, en);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1 done", done, 0);
    check("R1 valid", valid, 0);
    check("R1 not_found", not_found, 0);
    check("R1 n", n_o, 0);
    check("R1 p1", p1_o, 0);
    @(negedge clk); rst_n = 1'b1;
    run("R5 exact", 64'd21_800_000, 64'd96_000_000, -1);
    run("R6 just below exact", 64'd21_799_999, 64'd96_000_000, -1);
    run("R7 above reach", 64'd500_000_000, 64'd96_000_000, -1);
    run("R6 tiny target", 64'd1, 64'd96_000_000, -1);
    run("R4 top dot", 64'd400_000_000, 64'd96_000_000, -1);
    run("R9 busy start", 64'd148_500_000, 64'd96_000_000, 10);
    for (int i = 0; i < 10; i++)
      run("R6 random 96M", 64'd20_000_000 + 64'($urandom_range(400_000_000)),
          64'd96_000_000, -1);
    for (int i = 0; i < 3; i++)
      run("R3 random 100M", 64'd20_000_000 + 64'($urandom_range(380_000_000)),
          64'd100_000_000, -1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule